// File: doc/BRIEF.md
# Page Write Buffer and Current-Address Generator

This block keeps the current address of a serial memory with 8K single-byte locations and gathers the bytes of a page write before they reach the array. The serial controller in front of it loads a start address, hands over data bytes one at a time, pulses an increment after each byte it reads out, and finally strobes a commit. The block tells the controller where the next read comes from. After a commit it plays the buffered bytes into the array, one write per clock.

Reads and writes move through the address space differently. A read step carries into all thirteen bits and wraps from the top of memory to zero. A write step touches only the five in-page bits, so a burst that runs past the end of its 32-byte page folds back onto the start of that page. Each byte that folds back replaces the byte stored earlier at that offset. A valid bit per offset records which bytes arrived, and only those bytes are written to the array.

Top module: `pgbuf_addr_gen`

## Requirements
- R1: After reset, rd_addr is 0, arr_we is 0, commit_busy is 0 and commit_done is 0.
- R2: An accepted load_en sets rd_addr to load_addr in the next cycle. It discards every byte buffered before it, so none of them reaches the array at the next commit.
- R3: An accepted wr_en stores wr_data at the in-page offset rd_addr[4:0]. In the next cycle the low five bits of rd_addr have advanced by one and rd_addr[12:5] is unchanged.
- R4: A write at offset 31 moves rd_addr to offset 0 of the same page. A later byte at an offset that already holds data replaces the earlier byte.
- R5: An accepted rd_inc advances rd_addr by one over all 13 bits, so 8191 is followed by 0.
- R6: While the commit runs, arr_we is high for one cycle per valid offset, in ascending offset order, on consecutive cycles. arr_addr is {page of the last load, offset} and arr_wdata is the last byte written at that offset. Offsets that received no byte are never written.
- R7: commit_busy rises in the cycle after an accepted commit. commit_done is high for exactly one cycle, the cycle after the last array write, with arr_we low. In the following cycle commit_busy is low. With no valid bytes, commit_done is high in the first busy cycle.
- R8: If more than 32 bytes were written since the last load, rd_addr equals the load address from the cycle after an accepted commit. Otherwise rd_addr keeps the page-wrapped value that follows the last byte.
- R9: The valid bits are all clear once commit_done has been seen, so a second commit without new bytes writes nothing.
- R10: While commit_busy is high, load_en, wr_en, rd_inc and commit are ignored: rd_addr and the array writes are unaffected. When idle, the inputs take priority in the order commit, load_en, wr_en, rd_inc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load a new current address |
| load_addr | input | 13 | Address to load |
| wr_en | input | 1 | Buffer one data byte |
| wr_data | input | 8 | Byte to buffer |
| rd_inc | input | 1 | Step the address after a read byte |
| commit | input | 1 | Start writing buffered bytes to the array |
| rd_addr | output | 13 | Current address |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 13 | Array write address |
| arr_wdata | output | 8 | Array write data |
| commit_busy | output | 1 | Commit sequence in progress |
| commit_done | output | 1 | One-cycle pulse at the end of a commit |

## Verification
A table of single-step operations drives the address path. Read steps across the top of memory show that a read carry reaches every bit. Write bursts near the end of a page show that a write carry is cut off at bit 5. Three write patterns exercise the commit: a short burst that wraps into offset 0, which must come out in offset order rather than arrival order; an abandoned burst followed by a reload, which must leave no trace; and a 33-byte burst, which separates page-wrapped overwriting and the restore of the start address from the normal case. A repeated commit and stimulus applied during a busy commit show that the valid bits are cleared and that inputs are locked out.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_DRAIN = 1'b1
  } sq_state_e;

  // Step inside an aligned block of 2**pw: carry stops at bit pw.
  function automatic logic [31:0] page_step(input logic [31:0] a, input int unsigned pw);
    logic [31:0] m;
    m = (32'd1 << pw) - 32'd1;
    return (a & ~m) | ((a + 32'd1) & m);
  endfunction

  // Step over the full aw-bit range, wrapping to zero.
  function automatic logic [31:0] wrap_step(input logic [31:0] a, input int unsigned aw);
    logic [31:0] m;
    m = (aw >= 32) ? '1 : ((32'd1 << aw) - 32'd1);
    return (a + 32'd1) & m;
  endfunction

  // Index of the least significant set bit (0 when none is set).
  function automatic logic [5:0] lowest_set(input logic [63:0] m);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      if (m[i]) r = 6'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/pgbuf_addr_ctr.sv
module pgbuf_addr_ctr
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_step,
  input  logic              rd_step,
  input  logic              commit_go,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] base_addr,
  output logic              overflow
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = PAGE_W + 2;

  logic [CNT_W-1:0] wr_cnt;

  assign overflow = (wr_cnt > CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      base_addr <= '0;
      wr_cnt    <= '0;
    end else if (commit_go) begin
      if (overflow) cur_addr <= base_addr;
      wr_cnt <= '0;
    end else if (load_en) begin
      cur_addr  <= load_addr;
      base_addr <= load_addr;
      wr_cnt    <= '0;
    end else if (wr_step) begin
      cur_addr <= ADDR_W'(page_step(32'(cur_addr), PAGE_W));
      if (!overflow) wr_cnt <= wr_cnt + 1'b1;
    end else if (rd_step) begin
      cur_addr <= ADDR_W'(wrap_step(32'(cur_addr), ADDR_W));
    end
  end

endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_all,
  input  logic                 wr_en,
  input  logic [PAGE_W-1:0]    wr_off,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 drop_en,
  input  logic [PAGE_W-1:0]    drop_off,
  input  logic [PAGE_W-1:0]    rd_off,
  output logic [(1<<PAGE_W)-1:0] valid,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int NB = 1 << PAGE_W;

  logic [DATA_W-1:0] bytes_q [NB];
  logic [NB-1:0]     valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      valid_q <= '0;
    end else begin
      if (wr_en)   valid_q[wr_off]   <= 1'b1;
      if (drop_en) valid_q[drop_off] <= 1'b0;
    end
  end

  assign valid   = valid_q;
  assign rd_data = bytes_q[rd_off];

endmodule

// File: rtl/pgbuf_commit_seq.sv
module pgbuf_commit_seq
  import pgbuf_pkg::*;
#(
  parameter int PAGE_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic [(1<<PAGE_W)-1:0] valid,
  output logic                   busy,
  output logic                   done,
  output logic                   we,
  output logic [PAGE_W-1:0]      off,
  output logic                   pend_any
);
  sq_state_e state_q;

  assign pend_any = |valid;
  assign busy     = (state_q == SQ_DRAIN);
  assign we       = busy && pend_any;
  assign done     = busy && !pend_any;
  assign off      = PAGE_W'(lowest_set(64'(valid)));

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SQ_IDLE;
    else if (go)   state_q <= SQ_DRAIN;
    else if (done) state_q <= SQ_IDLE;
  end

endmodule

// File: rtl/pgbuf_addr_gen.sv
module pgbuf_addr_gen #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_inc,
  input  logic              commit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              commit_busy,
  output logic              commit_done
);
  localparam int NB = 1 << PAGE_W;

  // Named events, also observed by the checker.
  logic              go, load_acc, wr_acc, rd_acc, pend_any;
  logic [ADDR_W-1:0] base_addr;
  logic              overflow;
  logic [NB-1:0]     valid;
  logic [PAGE_W-1:0] seq_off;
  logic              busy_w;

  assign go       = commit && !busy_w;
  assign load_acc = load_en && !busy_w && !commit;
  assign wr_acc   = wr_en && !busy_w && !commit && !load_en;
  assign rd_acc   = rd_inc && !busy_w && !commit && !load_en && !wr_en;

  pgbuf_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_acc),
    .load_addr (load_addr),
    .wr_step   (wr_acc),
    .rd_step   (rd_acc),
    .commit_go (go),
    .cur_addr  (rd_addr),
    .base_addr (base_addr),
    .overflow  (overflow)
  );

  pgbuf_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (load_acc),
    .wr_en    (wr_acc),
    .wr_off   (rd_addr[PAGE_W-1:0]),
    .wr_data  (wr_data),
    .drop_en  (arr_we),
    .drop_off (seq_off),
    .rd_off   (seq_off),
    .valid    (valid),
    .rd_data  (arr_wdata)
  );

  pgbuf_commit_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .valid    (valid),
    .busy     (busy_w),
    .done     (commit_done),
    .we       (arr_we),
    .off      (seq_off),
    .pend_any (pend_any)
  );

  assign commit_busy = busy_w;
  assign arr_addr    = {base_addr[ADDR_W-1:PAGE_W], seq_off};

endmodule

// File: rtl/pgbuf_checker.sv
module pgbuf_checker #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              commit_busy,
  input logic              commit_done,
  input logic              wr_acc,
  input logic              rd_acc,
  input logic              pend_any
);

  assert_we_in_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> commit_busy);

  assert_offsets_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we) && $past(commit_busy))
      |-> (arr_addr[PAGE_W-1:0] > $past(arr_addr[PAGE_W-1:0])));

  assert_page_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (rd_addr[ADDR_W-1:PAGE_W] == $past(rd_addr[ADDR_W-1:PAGE_W])));

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> (!commit_done && !commit_busy));

  assert_done_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |-> (!pend_any && !arr_we));

  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_busy && $past(commit_busy)) |-> $stable(rd_addr));

endmodule

bind pgbuf_addr_gen pgbuf_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_addr     (rd_addr),
  .arr_we      (arr_we),
  .arr_addr    (arr_addr),
  .commit_busy (commit_busy),
  .commit_done (commit_done),
  .wr_acc      (wr_acc),
  .rd_acc      (rd_acc),
  .pend_any    (pend_any)
);

// File: tb/tb_pgbuf_addr_gen.sv
`timescale 1ns/1ps
module tb_pgbuf_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0, wr_en = 1'b0, rd_inc = 1'b0, commit = 1'b0;
  logic [12:0] load_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [12:0] rd_addr, arr_addr;
  logic        arr_we, commit_busy, commit_done;
  logic [7:0]  arr_wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pgbuf_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_inc(rd_inc), .commit(commit),
    .rd_addr(rd_addr), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .commit_busy(commit_busy), .commit_done(commit_done)
  );

  // Behavioural array fed by the commit port.
  logic [7:0] amem [8192];
  always_ff @(posedge clk) if (arr_we) amem[arr_addr] <= arr_wdata;

  // Log of one commit, filled at sample points.
  int          nw;
  logic [12:0] la [40];
  logic [7:0]  ld [40];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  localparam logic [1:0] OP_LD = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  typedef struct packed {
    logic [1:0]  op;
    logic [12:0] arg;
    logic [12:0] exp;
  } vec_t;

  // R2 load, R3 in-page step, R4 page fold, R5 full-range step and wrap.
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{OP_LD, 13'h0123, 13'h0123},
    '{OP_WR, 13'h00A5, 13'h0124},
    '{OP_WR, 13'h005A, 13'h0125},
    '{OP_RD, 13'h0000, 13'h0126},
    '{OP_LD, 13'h01FE, 13'h01FE},
    '{OP_WR, 13'h0011, 13'h01FF},
    '{OP_WR, 13'h0022, 13'h01E0},
    '{OP_WR, 13'h0033, 13'h01E1},
    '{OP_LD, 13'h1FFE, 13'h1FFE},
    '{OP_RD, 13'h0000, 13'h1FFF},
    '{OP_RD, 13'h0000, 13'h0000},
    '{OP_RD, 13'h0000, 13'h0001}
  };

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_op(input logic [1:0] op, input logic [12:0] arg);
    load_en = (op == OP_LD); wr_en = (op == OP_WR); rd_inc = (op == OP_RD);
    load_addr = arg; wr_data = arg[7:0];
    @(negedge clk);
    load_en = 1'b0; wr_en = 1'b0; rd_inc = 1'b0;
  endtask

  task automatic run_commit(input bit junk);
    logic [4:0] prev;
    bit first_we;
    bit saw_done;
    first_we = 1'b1; saw_done = 1'b0; prev = '0;
    nw = 0;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check(commit_busy == 1'b1, "R7", "busy after commit", commit_busy, 1);
    for (int it = 0; it < 40; it++) begin
      if (junk && it == 0) begin
        load_en = 1'b1; load_addr = 13'h1234; wr_en = 1'b1; wr_data = 8'hEE;
        rd_inc = 1'b1; commit = 1'b1;
      end else if (junk && it == 1) begin
        load_en = 1'b0; wr_en = 1'b0; rd_inc = 1'b0; commit = 1'b0;
      end
      if (arr_we) begin
        if (!first_we)
          check(arr_addr[4:0] > prev, "R6", "ascending offset", arr_addr[4:0], prev + 1);
        first_we = 1'b0;
        prev = arr_addr[4:0];
        la[nw] = arr_addr; ld[nw] = arr_wdata; nw++;
      end
      if (commit_done) begin
        saw_done = 1'b1;
        check(!arr_we, "R7", "no write with done", arr_we, 0);
        break;
      end
      @(negedge clk);
    end
    load_en = 1'b0; wr_en = 1'b0; rd_inc = 1'b0; commit = 1'b0;
    check(saw_done, "R7", "done seen", saw_done, 1);
    @(negedge clk);
    check(!commit_busy && !commit_done, "R7", "idle after done",
          {commit_busy, commit_done}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_addr == 13'h0, "R1", "rd_addr", rd_addr, 0);
    check(!arr_we && !commit_busy && !commit_done, "R1", "strobes",
          {arr_we, commit_busy, commit_done}, 0);

    // Address table
    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, VECS[i].arg);
      check(rd_addr == VECS[i].exp, "R2/R3/R4/R5", $sformatf("vector %0d", i),
            rd_addr, VECS[i].exp);
    end

    // R2: bytes before a reload are discarded
    do_op(OP_LD, 13'h0345);
    do_op(OP_WR, 13'h0010);
    do_op(OP_LD, 13'h0520);
    do_op(OP_WR, 13'h0077);
    run_commit(1'b0);
    check(nw == 1, "R2", "writes after reload", nw, 1);
    check(la[0] == 13'h0520 && ld[0] == 8'h77, "R2", "kept byte", {la[0], ld[0]}, {13'h0520, 8'h77});

    // R4/R6/R8: burst folding into offset 0, written in offset order
    do_op(OP_LD, 13'h035E);
    do_op(OP_WR, 13'h00A1);
    do_op(OP_WR, 13'h00B2);
    do_op(OP_WR, 13'h00C3);
    check(rd_addr == 13'h0341, "R4", "fold to page start", rd_addr, 13'h0341);
    run_commit(1'b0);
    check(nw == 3, "R6", "write count", nw, 3);
    check(la[0] == 13'h0340 && ld[0] == 8'hC3, "R6", "write 0", {la[0], ld[0]}, {13'h0340, 8'hC3});
    check(la[1] == 13'h035E && ld[1] == 8'hA1, "R6", "write 1", {la[1], ld[1]}, {13'h035E, 8'hA1});
    check(la[2] == 13'h035F && ld[2] == 8'hB2, "R6", "write 2", {la[2], ld[2]}, {13'h035F, 8'hB2});
    check(amem[13'h0340] == 8'hC3, "R6", "array content", amem[13'h0340], 8'hC3);
    check(rd_addr == 13'h0341, "R8", "short burst address", rd_addr, 13'h0341);

    // R9: second commit finds nothing
    run_commit(1'b0);
    check(nw == 0, "R9", "empty commit writes", nw, 0);

    // R4/R8: 33-byte burst from offset 7
    do_op(OP_LD, 13'h0407);
    for (int j = 0; j < 33; j++) do_op(OP_WR, 13'(8'h40 + j));
    check(rd_addr == 13'h0408, "R4", "after 33 bytes", rd_addr, 13'h0408);
    run_commit(1'b0);
    check(rd_addr == 13'h0407, "R8", "restored start", rd_addr, 13'h0407);
    check(nw == 32, "R6", "full page writes", nw, 32);
    for (int o = 0; o < 32; o++) begin
      int jj;
      logic [7:0] ex;
      jj = (o == 7) ? 32 : ((o - 7 + 32) % 32);
      ex = 8'(8'h40 + jj);
      check(la[o] == 13'(13'h0400 + o) && ld[o] == ex, "R4",
            $sformatf("page byte %0d", o), ld[o], ex);
    end

    // R10: inputs ignored while busy
    do_op(OP_LD, 13'h0800);
    do_op(OP_WR, 13'h0081);
    do_op(OP_WR, 13'h0082);
    run_commit(1'b1);
    check(nw == 2, "R10", "writes during lockout", nw, 2);
    check(la[1] == 13'h0801 && ld[1] == 8'h82, "R10", "last write", {la[1], ld[1]}, {13'h0801, 8'h82});
    check(rd_addr == 13'h0802, "R10", "address held", rd_addr, 13'h0802);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule